// File: doc/BRIEF.md
# Panel Sync Timing Generator

This block produces the raster timing for a parallel TFT panel. A programmable divider turns the fast system clock into a pixel clock enable. Two copies of a four-segment timer run off that enable. The horizontal copy counts pixel periods and the vertical copy counts whole lines. From their state the block drives a line sync, a frame sync, a data-enable strobe and the pixel position inside the visible area. Downstream logic shifts a pixel out on each enable while the strobe is high.

Each timing field is a biased count, and the bias depends on the field. The geometry fields are captured at the first pixel period of every frame, so software can rewrite them at any time and the new values take effect from the next frame. The sync polarity selects and the strobe-only mode act at once. The strobe-only mode is for panels that must see both syncs held low.

Top module: `lcd_sync_gen`

## Requirements
- R1: `pix_ce` is high for one system clock in every `cfg_div`+1 clocks; after reset is released, the first pulse comes in the clock with index `cfg_div`, counting from 0.
- R2: A line is four pixel-period segments in this order: strobe high for `cfg_h_active_m1`+1, strobe low for `cfg_h_front`+1 before the line sync, line sync active for `cfg_h_sync`+1, then `cfg_h_back`+3 more before the strobe rises again.
- R3: A frame is four line segments in this order: frame sync active for `cfg_v_sync`+1 lines, `cfg_v_back`+1 idle lines, `cfg_v_active_m1`+1 visible lines, then `cfg_v_front`+1 idle lines. Every segment change falls on the first pixel period of a line.
- R4: `de` is high only in the strobe segment of visible lines. While it is high, `px_x` counts 0 to `cfg_h_active_m1` along the line and `px_y` counts 0 to `cfg_v_active_m1` down the frame. All outputs change only on the clock edge that follows a `pix_ce` pulse.
- R5: With `hs_active_low`=1 the line sync is driven low when active and high otherwise, and with 0 the reverse. `vs_active_low` does the same for the frame sync. Both selects apply at once.
- R6: While `de_only_mode`=1, both `hsync` and `vsync` are held at 0, and `de` keeps its normal timing.
- R7: The geometry fields are sampled on the pixel period that starts a frame, which is the first frame-sync line. A change made in the middle of a frame leaves the rest of that frame on the old timing.
- R8: `frame_start` is high for exactly one system clock, together with the first strobe pixel of each frame (`px_x`=0, `px_y`=0). It is low at all other times.
- R9: During reset `de`, `frame_start`, `px_x` and `px_y` are 0 and both syncs sit at their inactive level. The first frame begins on the first `pix_ce` pulse.
- R10: Every field must stay at least 3 below its all-ones value, so that the biased limit of each segment fits in the counter width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Pixel divider; one enable every value+1 clocks |
| cfg_h_active_m1 | input | H_W | Visible pixels per line minus one |
| cfg_h_front | input | H_W | Strobe end to line sync start, minus one |
| cfg_h_sync | input | H_W | Line sync width minus one |
| cfg_h_back | input | H_W | Line sync end to strobe start, minus three |
| cfg_v_active_m1 | input | V_W | Visible lines minus one |
| cfg_v_sync | input | V_W | Frame sync lines minus one |
| cfg_v_back | input | V_W | Lines between frame sync and visible area, minus one |
| cfg_v_front | input | V_W | Lines between visible area and frame sync, minus one |
| hs_active_low | input | 1 | Line sync active level is low |
| vs_active_low | input | 1 | Frame sync active level is low |
| de_only_mode | input | 1 | Hold both syncs at 0 |
| pix_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data-enable strobe |
| px_x | output | H_W | Pixel column inside the visible area |
| px_y | output | V_W | Line inside the visible area |
| frame_start | output | 1 | One-clock marker at the first visible pixel |

## Verification
The assertions assume that every field stays within the limit of R10, so that no segment collapses to zero length or wraps its counter. They also assume that configuration inputs change only between clock edges. The stimulus draws small random fields well inside those limits and changes inputs only at falling clock edges. It changes the geometry in the middle of a frame only in the dedicated test for R7. The polarity and strobe-only selects are changed only at reset, so the bench model can treat them as constant over each run.

// File: rtl/lcd_sync_pkg.sv
`timescale 1ns/1ps
package lcd_sync_pkg;
  // Four segments per timer. Horizontal: visible, front, sync, back.
  // Vertical: sync, back, visible, front.
  typedef enum logic [1:0] {SEG_A = 2'd0, SEG_B = 2'd1, SEG_C = 2'd2, SEG_D = 2'd3} seg_e;

  // Bias added to each field to give its segment length.
  localparam int H_ACT_BIAS   = 1;
  localparam int H_FRONT_BIAS = 1;
  localparam int H_SYNC_BIAS  = 1;
  localparam int H_BACK_BIAS  = 3;
  localparam int V_BIAS       = 1;
endpackage

// File: rtl/lcd_pix_div.sv
`timescale 1ns/1ps
module lcd_pix_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             ce_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  // >= keeps the divider safe when the divisor drops below the count
  assign ce_o = (cnt_q >= div_i);

  always_comb begin
    cnt_d = ce_o ? '0 : DIV_W'(cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lcd_seg_timer.sv
`timescale 1ns/1ps
module lcd_seg_timer
  import lcd_sync_pkg::*;
#(
  parameter int W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              restart_i,
  input  logic [3:0][W-1:0] lim_i,
  output seg_e              seg_o,
  output logic [W-1:0]      cnt_o,
  output logic              at_lim_o
);
  seg_e         seg_q, seg_d;
  logic [W-1:0] cnt_q, cnt_d;

  assign at_lim_o = (cnt_q == lim_i[seg_q]);

  always_comb begin
    seg_d = seg_q;
    cnt_d = cnt_q;
    if (restart_i) begin
      seg_d = SEG_A;
      cnt_d = '0;
    end else if (step_i) begin
      if (at_lim_o) begin
        seg_d = seg_e'(2'(seg_q + 2'd1));
        cnt_d = '0;
      end else begin
        cnt_d = W'(cnt_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_A;
      cnt_q <= '0;
    end else begin
      seg_q <= seg_d;
      cnt_q <= cnt_d;
    end
  end

  assign seg_o = seg_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/lcd_sync_pol.sv
`timescale 1ns/1ps
module lcd_sync_pol (
  input  logic hs_act_i,
  input  logic vs_act_i,
  input  logic hs_low_i,
  input  logic vs_low_i,
  input  logic hold_low_i,
  output logic hsync_o,
  output logic vsync_o
);
  always_comb begin
    hsync_o = !hold_low_i && (hs_act_i ^ hs_low_i);
    vsync_o = !hold_low_i && (vs_act_i ^ vs_low_i);
  end
endmodule

// File: rtl/lcd_sync_gen.sv
`timescale 1ns/1ps
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int H_W   = 12,
  parameter int V_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [H_W-1:0]   cfg_h_active_m1,
  input  logic [H_W-1:0]   cfg_h_front,
  input  logic [H_W-1:0]   cfg_h_sync,
  input  logic [H_W-1:0]   cfg_h_back,
  input  logic [V_W-1:0]   cfg_v_active_m1,
  input  logic [V_W-1:0]   cfg_v_sync,
  input  logic [V_W-1:0]   cfg_v_back,
  input  logic [V_W-1:0]   cfg_v_front,
  input  logic             hs_active_low,
  input  logic             vs_active_low,
  input  logic             de_only_mode,
  output logic             pix_ce,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [H_W-1:0]   px_x,
  output logic [V_W-1:0]   px_y,
  output logic             frame_start
);
  // Segment limit = length - 1 = field + bias - 1
  localparam logic [H_W-1:0] H_ACT_ADJ   = H_W'(H_ACT_BIAS - 1);
  localparam logic [H_W-1:0] H_FRONT_ADJ = H_W'(H_FRONT_BIAS - 1);
  localparam logic [H_W-1:0] H_SYNC_ADJ  = H_W'(H_SYNC_BIAS - 1);
  localparam logic [H_W-1:0] H_BACK_ADJ  = H_W'(H_BACK_BIAS - 1);
  localparam logic [V_W-1:0] V_ADJ       = V_W'(V_BIAS - 1);

  logic                 ce;
  logic                 started_q, started_d;
  logic                 fs_q, fs_d;
  logic [3:0][H_W-1:0]  hlim_q, hlim_d, hlim_in;
  logic [3:0][V_W-1:0]  vlim_q, vlim_d, vlim_in;
  seg_e                 h_seg, v_seg;
  logic [H_W-1:0]       h_cnt;
  logic [V_W-1:0]       v_cnt;
  logic                 h_at_lim, v_at_lim;
  logic                 h_wrap, v_wrap, line_end, restart, frame_begin;

  lcd_pix_div #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .div_i (cfg_div),
    .ce_o  (ce)
  );

  // Biased limits from the live fields, in each timer's segment order
  always_comb begin
    hlim_in[0] = H_W'(cfg_h_active_m1 + H_ACT_ADJ);
    hlim_in[1] = H_W'(cfg_h_front     + H_FRONT_ADJ);
    hlim_in[2] = H_W'(cfg_h_sync      + H_SYNC_ADJ);
    hlim_in[3] = H_W'(cfg_h_back      + H_BACK_ADJ);
    vlim_in[0] = V_W'(cfg_v_sync      + V_ADJ);
    vlim_in[1] = V_W'(cfg_v_back      + V_ADJ);
    vlim_in[2] = V_W'(cfg_v_active_m1 + V_ADJ);
    vlim_in[3] = V_W'(cfg_v_front     + V_ADJ);
  end

  always_comb begin
    h_wrap      = h_at_lim && (h_seg == SEG_D);
    v_wrap      = v_at_lim && (v_seg == SEG_D);
    line_end    = ce && h_wrap;
    restart     = ce && !started_q;
    frame_begin = restart || (line_end && v_wrap);
    started_d   = started_q || ce;
    hlim_d      = frame_begin ? hlim_in : hlim_q;
    vlim_d      = frame_begin ? vlim_in : vlim_q;
    // next line is the first visible one, and its first pixel is visible
    fs_d        = line_end && (v_seg == SEG_B) && v_at_lim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      fs_q      <= 1'b0;
      hlim_q    <= '0;
      vlim_q    <= '0;
    end else begin
      started_q <= started_d;
      fs_q      <= fs_d;
      hlim_q    <= hlim_d;
      vlim_q    <= vlim_d;
    end
  end

  lcd_seg_timer #(.W(H_W)) u_htmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (ce),
    .restart_i (restart),
    .lim_i     (hlim_q),
    .seg_o     (h_seg),
    .cnt_o     (h_cnt),
    .at_lim_o  (h_at_lim)
  );

  lcd_seg_timer #(.W(V_W)) u_vtmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (line_end),
    .restart_i (restart),
    .lim_i     (vlim_q),
    .seg_o     (v_seg),
    .cnt_o     (v_cnt),
    .at_lim_o  (v_at_lim)
  );

  lcd_sync_pol u_pol (
    .hs_act_i   (started_q && (h_seg == SEG_C)),
    .vs_act_i   (started_q && (v_seg == SEG_A)),
    .hs_low_i   (hs_active_low),
    .vs_low_i   (vs_active_low),
    .hold_low_i (de_only_mode),
    .hsync_o    (hsync),
    .vsync_o    (vsync)
  );

  assign pix_ce      = ce;
  assign de          = started_q && (h_seg == SEG_A) && (v_seg == SEG_C);
  assign px_x        = h_cnt;
  assign px_y        = v_cnt;
  assign frame_start = fs_q;
endmodule

// File: rtl/lcd_sync_gen_chk.sv
`timescale 1ns/1ps
module lcd_sync_gen_chk #(
  parameter int DIV_W = 8,
  parameter int H_W   = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] cfg_div,
  input logic             hs_active_low,
  input logic             vs_active_low,
  input logic             de_only_mode,
  input logic             pix_ce,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic [H_W-1:0]   px_x,
  input logic             frame_start
);
  logic ce_prev, seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_prev <= 1'b0;
      seen    <= 1'b0;
    end else begin
      ce_prev <= pix_ce;
      seen    <= 1'b1;
    end
  end

  p_ce_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ce |=> (!pix_ce || cfg_div == '0));

  p_hs_idle_in_de_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (de && !de_only_mode) |-> (hsync == hs_active_low));

  p_vs_idle_in_de_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (de && !de_only_mode) |-> (vsync == vs_active_low));

  p_hold_between_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !ce_prev) |-> ($stable(de) && $stable(px_x)));

  p_syncs_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    de_only_mode |-> (!hsync && !vsync));

  p_fs_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  p_fs_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (de && px_x == '0));
endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(.DIV_W(DIV_W), .H_W(H_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_div       (cfg_div),
  .hs_active_low (hs_active_low),
  .vs_active_low (vs_active_low),
  .de_only_mode  (de_only_mode),
  .pix_ce        (pix_ce),
  .hsync         (hsync),
  .vsync         (vsync),
  .de            (de),
  .px_x          (px_x),
  .frame_start   (frame_start)
);

// File: tb/lcd_sync_gen_test.sv
`timescale 1ns/1ps
module lcd_sync_gen_test;
  localparam int DIV_W = 8, H_W = 12, V_W = 11;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [DIV_W-1:0] cfg_div;
  logic [H_W-1:0]   ha, hf, hs, hb;
  logic [V_W-1:0]   va, vs, vb, vf;
  logic hlow, vlow, deo;
  logic pix_ce, hsync, vsync, de, frame_start;
  logic [H_W-1:0] px_x;
  logic [V_W-1:0] px_y;

  lcd_sync_gen #(.DIV_W(DIV_W), .H_W(H_W), .V_W(V_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
    .cfg_h_active_m1(ha), .cfg_h_front(hf), .cfg_h_sync(hs), .cfg_h_back(hb),
    .cfg_v_active_m1(va), .cfg_v_sync(vs), .cfg_v_back(vb), .cfg_v_front(vf),
    .hs_active_low(hlow), .vs_active_low(vlow), .de_only_mode(deo),
    .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de),
    .px_x(px_x), .px_y(px_y), .frame_start(frame_start)
  );

  int errors = 0, checks = 0;
  string tag = "";
  // bench model state
  int k, base, m_frame, m_line, since;
  int m_ha, m_hf, m_hs, m_hb, m_va, m_vs, m_vb, m_vf;
  bit prev_tick;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic int frame_clks();
    return ((int'(ha) + 1) + (int'(hf) + 1) + (int'(hs) + 1) + (int'(hb) + 3)) *
           (int'(va) + int'(vs) + int'(vb) + int'(vf) + 4) * (int'(cfg_div) + 1);
  endfunction

  task automatic model_step();
    int f, line, col, e_de, e_hs, e_vs, e_fs;
    if (k - base == m_frame) begin  // R7: geometry taken at frame start
      m_ha = int'(ha) + 1; m_hf = int'(hf) + 1; m_hs = int'(hs) + 1; m_hb = int'(hb) + 3;
      m_va = int'(va) + 1; m_vs = int'(vs) + 1; m_vb = int'(vb) + 1; m_vf = int'(vf) + 1;
      m_line  = m_ha + m_hf + m_hs + m_hb;
      m_frame = m_line * (m_va + m_vs + m_vb + m_vf);
      base    = k;
    end
    f = k - base;
    line = f / m_line;
    col  = f % m_line;
    e_de = (col < m_ha && line >= m_vs + m_vb && line < m_vs + m_vb + m_va) ? 1 : 0;
    e_hs = (col >= m_ha + m_hf && col < m_ha + m_hf + m_hs) ? 1 : 0;
    e_vs = (line < m_vs) ? 1 : 0;
    e_fs = (f == (m_vs + m_vb) * m_line) ? 1 : 0;
    chk("R2/R5/R6 hsync", int'(hsync), deo ? 0 : (e_hs ^ int'(hlow)));
    chk("R3/R5/R6 vsync", int'(vsync), deo ? 0 : (e_vs ^ int'(vlow)));
    chk("R4 de", int'(de), e_de);
    if (e_de == 1) begin
      chk("R4 px_x", int'(px_x), col);
      chk("R4 px_y", int'(px_y), line - m_vs - m_vb);
    end
    chk("R8 frame_start", int'(frame_start), e_fs);
    k++;
  endtask

  task automatic eval();
    if (prev_tick) model_step();
    else chk("R8 frame_start quiet", int'(frame_start), 0);
    if (pix_ce) begin
      chk("R1 enable spacing", since, int'(cfg_div) + 1);
      since = 1;
    end else begin
      since++;
    end
    prev_tick = pix_ce;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      eval();
      @(negedge clk); #1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R9: idle outputs in reset
    chk("R9 de", int'(de), 0);
    chk("R9 frame_start", int'(frame_start), 0);
    chk("R9 px_x", int'(px_x), 0);
    chk("R9 px_y", int'(px_y), 0);
    chk("R9 hsync", int'(hsync), deo ? 0 : int'(hlow));
    chk("R9 vsync", int'(vsync), deo ? 0 : int'(vlow));
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    k = 0; base = 0; m_frame = 0; m_line = 1; since = 1; prev_tick = 0;
  endtask

  task automatic set_geom(int d, int a, int b, int c, int e, int p, int q, int r, int s);
    cfg_div = DIV_W'(d);
    ha = H_W'(a); hf = H_W'(b); hs = H_W'(c); hb = H_W'(e);
    va = V_W'(p); vs = V_W'(q); vb = V_W'(r); vf = V_W'(s);
  endtask

  task automatic rand_geom();
    set_geom($urandom_range(0, 3), $urandom_range(0, 19), $urandom_range(0, 3),
             $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 9),
             $urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 2));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; hlow = 1'b0; vlow = 1'b0; deo = 1'b0;
    // minimum fields, enable every clock (R1, R2, R3, R9, R10)
    tag = "min";
    set_geom(0, 0, 0, 0, 0, 0, 0, 0, 0);
    do_reset();
    run(3 * frame_clks() + 5);
    // slow divider of twelve
    tag = "div12";
    set_geom(11, 7, 1, 2, 0, 3, 1, 0, 1);
    do_reset();
    run(2 * frame_clks() + 5);
    // R5: both syncs active low
    tag = "R5";
    hlow = 1'b1; vlow = 1'b1;
    set_geom(1, 9, 2, 1, 2, 4, 0, 1, 2);
    do_reset();
    run(2 * frame_clks() + 5);
    // R5: mixed polarity
    hlow = 1'b0; vlow = 1'b1;
    do_reset();
    run(frame_clks() + 5);
    // R6: strobe-only mode
    tag = "R6";
    deo = 1'b1; hlow = 1'b1;
    set_geom(2, 5, 0, 3, 1, 2, 1, 1, 0);
    do_reset();
    run(2 * frame_clks() + 5);
    deo = 1'b0; hlow = 1'b0; vlow = 1'b0;
    // random geometries
    for (int t = 0; t < 5; t++) begin
      tag = "rand";
      rand_geom();
      hlow = 1'(t[0]); vlow = 1'(t[1]);
      do_reset();
      run(2 * frame_clks() + 5);
    end
    // R7: geometry rewritten part way through a frame
    tag = "R7";
    hlow = 1'b0; vlow = 1'b0;
    set_geom(1, 6, 1, 1, 1, 3, 1, 1, 1);
    do_reset();
    run(frame_clks() + frame_clks() / 2);
    set_geom(1, 11, 0, 2, 3, 5, 0, 2, 0);
    run(3 * frame_clks() + 5);
    finish_up();
  end
endmodule